// File: doc/BRIEF.md
# Flash Sector Secondary Lock Register

This block keeps a second set of per-sector protection bits for an embedded flash, beside the primary lock register. Six sectors sit in the low address space and two in the mid address space. The bits are held in two 16-bit register fields that a simple register bus reads and writes. At reset, each bit loads from a configuration word held in non-volatile test storage. A per-sector presence mask is also sampled at reset. Sectors that are absent stay locked permanently.

Writes are accepted only under three conditions: the enable input is high, no program or erase operation is in flight, and no high-voltage operation is suspended. An operation counts as in flight from an interlock write until the controller's done flag. A write that is refused changes nothing and produces a one-cycle indication.

The block merges its bits with the primary lock bits. The result is the effective lock vector that the program/erase sequencer obeys.

Top module: `sec_lock_reg`

## Requirements
- R1: `eff_lock[i]` is 1 (sector protected) when either `prim_lock[i]` or the secondary bit of sector i is 1. It is 0 (sector may be programmed or erased) only when both are 0.
- R2: With `rd_sel` = 0 (low field), `rd_data[5:0]` hold sectors 0..5, with bit i mapping to sector i. `rd_data[15:6]` always read 1, and writes to those bits have no effect.
- R3: With `rd_sel` = 1 (mid field), `rd_data[0]` holds sector 6 and `rd_data[1]` holds sector 7. `rd_data[15:2]` always read 1.
- R4: During reset, each present sector's bit loads from `cfg_word`. Sectors 0..5 take `cfg_word[5:0]`, and sectors 6 and 7 take `cfg_word[16]` and `cfg_word[17]`. An all-ones word leaves every sector locked.
- R5: `sect_present` is sampled only while `rst` is high. A sector marked absent resets to 1 whatever `cfg_word` holds, and accepted writes leave its bit at 1.
- R6: A cycle with `ilk_write` high marks an operation busy from the next cycle onward. The busy state clears after the first cycle with `op_done` high. Writes presented while busy are refused. This includes a write in the same cycle as `op_done`. If `ilk_write` and `op_done` are high together, the block stays busy.
- R7: A write presented while `hv_suspended` is high is refused.
- R8: A write presented while `sec_enable` is low is refused.
- R9: An accepted write updates the field selected by `wr_sel` (0 = low, 1 = mid) at the clock edge. A refused write leaves both fields unchanged. `wr_ignored` is high for exactly the one cycle after each refused write, and is low otherwise.
- R10: Reads are combinational and have no side effects. Changing `rd_sel` never alters the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word | input | 18 | Non-volatile reset image: low field in [15:0], mid field in [17:16] |
| sect_present | input | 8 | Per-sector presence mask, sampled during reset |
| sec_enable | input | 1 | Write enable for the secondary lock register |
| ilk_write | input | 1 | Interlock write that starts a program/erase operation |
| op_done | input | 1 | Controller done flag |
| hv_suspended | input | 1 | High-voltage operation currently suspended |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write field select: 0 low, 1 mid |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read field select: 0 low, 1 mid |
| rd_data | output | 16 | Read data of the selected field |
| prim_lock | input | 8 | Primary per-sector lock bits |
| eff_lock | output | 8 | Effective per-sector lock (1 = protected) |
| wr_ignored | output | 1 | One-cycle pulse after a refused write |

## Verification
A corrupted stored bit shows up immediately on `eff_lock` whenever the matching primary bit is 0. It also shows on `rd_data` in the same cycle that field is selected, so the bench sees it on the next compare. A wrong busy state changes whether a write lands. That difference appears one cycle later, both as a flipped `wr_ignored` pulse and as stale or altered read data. A wrongly sampled presence mask is exposed as soon as a write tries to clear an absent sector's bit.

// File: rtl/sl_pkg.sv
`timescale 1ns/1ps
package sl_pkg;
    localparam int SL_FIELD_W = 16;
    localparam int SL_N_LOW   = 6;
    localparam int SL_N_MID   = 2;

    typedef enum logic {
        FLD_LOW = 1'b0,
        FLD_MID = 1'b1
    } fld_e;

    typedef struct packed {
        logic  en;
        fld_e  fld;
    } wr_ctl_t;

    function automatic fld_e sect_field(input int idx, input int n_low);
        return (idx < n_low) ? FLD_LOW : FLD_MID;
    endfunction

    function automatic int sect_bitpos(input int idx, input int n_low);
        return (idx < n_low) ? idx : idx - n_low;
    endfunction

    function automatic int sect_cfgbit(input int idx, input int n_low, input int field_w);
        return (idx < n_low) ? idx : field_w + idx - n_low;
    endfunction
endpackage

// File: rtl/sl_gate.sv
`timescale 1ns/1ps
module sl_gate (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic sec_enable,
    input  logic hv_suspended,
    input  logic ilk_write,
    input  logic op_done,
    output logic accept,
    output logic wr_ignored
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst)            busy_q <= 1'b0;
        else if (ilk_write) busy_q <= 1'b1;
        else if (op_done)   busy_q <= 1'b0;
    end

    assign accept = sec_enable && !busy_q && !hv_suspended;

    always_ff @(posedge clk) begin
        if (rst) wr_ignored <= 1'b0;
        else     wr_ignored <= wr_en && !accept;
    end

    // R6: an interlock write closes the write window on the following cycle
    p_ilk_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        ilk_write |=> !accept);

    // R7: a suspended high-voltage operation refuses the write and pulses
    p_hv_refuse_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hv_suspended) |=> wr_ignored);

    // R8: disabled register refuses the write
    p_enable_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !sec_enable) |=> wr_ignored);

    // R9: the pulse only ever follows a write attempt
    p_pulse_src_r9: assert property (@(posedge clk) disable iff (rst)
        wr_ignored |-> $past(wr_en));
endmodule

// File: rtl/sl_bank.sv
`timescale 1ns/1ps
module sl_bank
    import sl_pkg::*;
#(
    parameter int FIELD_W = SL_FIELD_W,
    parameter int N_LOW   = SL_N_LOW,
    parameter int N_MID   = SL_N_MID,
    localparam int NSECT  = N_LOW + N_MID,
    localparam int CFG_W  = FIELD_W + N_MID
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic [NSECT-1:0]   sect_present,
    input  wr_ctl_t            wr_ctl,
    input  logic [FIELD_W-1:0] wr_data,
    output logic [NSECT-1:0]   lock
);
    logic unused_cfg_hi;
    logic unused_wdata_hi;
    assign unused_cfg_hi   = ^cfg_word[FIELD_W-1:N_LOW];
    assign unused_wdata_hi = ^wr_data[FIELD_W-1:N_LOW];

    for (genvar i = 0; i < NSECT; i++) begin : g_sect
        localparam fld_e FLD  = sect_field(i, N_LOW);
        localparam int   POS  = sect_bitpos(i, N_LOW);
        localparam int   CFGB = sect_cfgbit(i, N_LOW, FIELD_W);

        logic pres_q;
        logic lock_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                pres_q <= sect_present[i];
                lock_q <= sect_present[i] ? cfg_word[CFGB] : 1'b1;
            end else if (wr_ctl.en && (wr_ctl.fld == FLD) && pres_q) begin
                lock_q <= wr_data[POS];
            end
        end

        assign lock[i] = lock_q;

        // R5: an absent sector never leaves the locked state
        p_absent_locked_r5: assert property (@(posedge clk) disable iff (rst)
            !pres_q |-> lock_q);
    end
endmodule

// File: rtl/sl_readmux.sv
`timescale 1ns/1ps
module sl_readmux
    import sl_pkg::*;
#(
    parameter int FIELD_W = SL_FIELD_W,
    parameter int N_LOW   = SL_N_LOW,
    parameter int N_MID   = SL_N_MID,
    localparam int NSECT  = N_LOW + N_MID
) (
    input  logic [NSECT-1:0]   lock,
    input  fld_e               rd_fld,
    output logic [FIELD_W-1:0] rd_data
);
    logic [FIELD_W-1:0] low_v;
    logic [FIELD_W-1:0] mid_v;

    always_comb begin
        low_v = '1;
        mid_v = '1;
        low_v[N_LOW-1:0] = lock[N_LOW-1:0];
        mid_v[N_MID-1:0] = lock[NSECT-1:N_LOW];
    end

    assign rd_data = (rd_fld == FLD_MID) ? mid_v : low_v;
endmodule

// File: rtl/sec_lock_reg.sv
`timescale 1ns/1ps
module sec_lock_reg
    import sl_pkg::*;
#(
    parameter int FIELD_W = SL_FIELD_W,
    parameter int N_LOW   = SL_N_LOW,
    parameter int N_MID   = SL_N_MID,
    localparam int NSECT  = N_LOW + N_MID,
    localparam int CFG_W  = FIELD_W + N_MID
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CFG_W-1:0]   cfg_word,
    input  logic [NSECT-1:0]   sect_present,
    input  logic               sec_enable,
    input  logic               ilk_write,
    input  logic               op_done,
    input  logic               hv_suspended,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic               rd_sel,
    output logic [FIELD_W-1:0] rd_data,
    input  logic [NSECT-1:0]   prim_lock,
    output logic [NSECT-1:0]   eff_lock,
    output logic               wr_ignored
);
    logic             accept;
    wr_ctl_t          wr_ctl;
    logic [NSECT-1:0] sec_lock;

    sl_gate u_gate (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .sec_enable   (sec_enable),
        .hv_suspended (hv_suspended),
        .ilk_write    (ilk_write),
        .op_done      (op_done),
        .accept       (accept),
        .wr_ignored   (wr_ignored)
    );

    assign wr_ctl.en  = wr_en && accept;
    assign wr_ctl.fld = fld_e'(wr_sel);

    sl_bank #(.FIELD_W(FIELD_W), .N_LOW(N_LOW), .N_MID(N_MID)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .cfg_word     (cfg_word),
        .sect_present (sect_present),
        .wr_ctl       (wr_ctl),
        .wr_data      (wr_data),
        .lock         (sec_lock)
    );

    sl_readmux #(.FIELD_W(FIELD_W), .N_LOW(N_LOW), .N_MID(N_MID)) u_rd (
        .lock    (sec_lock),
        .rd_fld  (fld_e'(rd_sel)),
        .rd_data (rd_data)
    );

    assign eff_lock = sec_lock | prim_lock;

    // R9: a refused write leaves every stored bit as it was
    p_refused_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !accept) |=> $stable(sec_lock));

    // R10: with no write strobe the stored bits hold, whatever is read
    p_read_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(sec_lock));
endmodule

// File: tb/sim_sec_lock_reg.sv
`timescale 1ns/1ps
module sim_sec_lock_reg;
    logic        clk = 1'b0;
    logic        rst;
    logic [17:0] cfg_word;
    logic [7:0]  sect_present;
    logic        sec_enable, ilk_write, op_done, hv_suspended;
    logic        wr_en, wr_sel, rd_sel;
    logic [15:0] wr_data;
    logic [15:0] rd_data;
    logic [7:0]  prim_lock, eff_lock;
    logic        wr_ignored;

    always #2.5 clk = ~clk;

    sec_lock_reg u0 (
        .clk(clk), .rst(rst), .cfg_word(cfg_word), .sect_present(sect_present),
        .sec_enable(sec_enable), .ilk_write(ilk_write), .op_done(op_done),
        .hv_suspended(hv_suspended), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .prim_lock(prim_lock), .eff_lock(eff_lock), .wr_ignored(wr_ignored)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    bit m_lock [8];
    bit m_pres [8];
    bit m_busy;
    bit m_ign;

    task automatic chk(string tag);
        logic [15:0] exp_rd;
        logic [7:0]  exp_eff;
        exp_rd = 16'hFFFF;
        for (int i = 0; i < 8; i++) begin
            if (rd_sel == 1'b0 && i < 6)  exp_rd[i]   = m_lock[i];
            if (rd_sel == 1'b1 && i >= 6) exp_rd[i-6] = m_lock[i];
            exp_eff[i] = m_lock[i] | prim_lock[i];
        end
        checks++;
        if (rd_data !== exp_rd) begin
            errors++;
            $display("FAIL %s rd_data act %h exp %h", tag, rd_data, exp_rd);
        end
        checks++;
        if (eff_lock !== exp_eff) begin
            errors++;
            $display("FAIL %s eff_lock act %b exp %b", tag, eff_lock, exp_eff);
        end
        checks++;
        if (wr_ignored !== m_ign) begin
            errors++;
            $display("FAIL %s wr_ignored act %b exp %b", tag, wr_ignored, m_ign);
        end
    endtask

    task automatic model_edge();
        bit acc;
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_pres[i] = sect_present[i];
                m_lock[i] = sect_present[i] ? cfg_word[(i < 6) ? i : 16 + i - 6] : 1'b1;
            end
            m_busy = 0;
            m_ign  = 0;
        end else begin
            acc = sec_enable && !m_busy && !hv_suspended;
            if (wr_en && acc) begin
                for (int i = 0; i < 8; i++) begin
                    if (m_pres[i] && (wr_sel == ((i < 6) ? 1'b0 : 1'b1)))
                        m_lock[i] = wr_data[(i < 6) ? i : i - 6];
                end
            end
            m_ign = wr_en && !acc;
            if (ilk_write)    m_busy = 1;
            else if (op_done) m_busy = 0;
        end
    endtask

    // inputs are set after a falling edge; compare, then advance one clock
    task automatic cyc(string tag);
        #1;
        chk(tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; ilk_write = 0; op_done = 0;
    endtask

    task automatic do_reset(logic [17:0] cfg, logic [7:0] pres);
        rst = 1; cfg_word = cfg; sect_present = pres; idle();
        cyc("R4");
        rst = 0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired act running exp finished");
        finish_run();
    end

    initial begin
        rst = 1; cfg_word = '1; sect_present = '1; sec_enable = 0;
        ilk_write = 0; op_done = 0; hv_suspended = 0; wr_en = 0;
        wr_sel = 0; wr_data = 0; rd_sel = 0; prim_lock = 0;
        @(negedge clk);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rst = 0;
        // R4: erased image leaves all sectors locked
        cyc("R4");
        rd_sel = 1; cyc("R4");

        // R4 / R5: pattern image with sector 6 absent
        do_reset(18'b10_0000000000_010101, 8'b1011_1111);
        rd_sel = 0; cyc("R4");
        rd_sel = 1; cyc("R5");

        // R8: disabled register refuses
        sec_enable = 0; wr_en = 1; wr_sel = 0; wr_data = 16'h0000; rd_sel = 0;
        cyc("R8");
        idle(); cyc("R8");

        // R9 / R2: accepted low write, upper bits stay 1
        sec_enable = 1; wr_en = 1; wr_sel = 0; wr_data = 16'h0000;
        cyc("R9");
        idle(); cyc("R2");
        wr_en = 1; wr_data = 16'hFFEA; cyc("R2");
        idle(); cyc("R2");

        // R3 / R5: mid write, absent sector 6 stays locked
        wr_en = 1; wr_sel = 1; wr_data = 16'h0000; rd_sel = 1;
        cyc("R3");
        idle(); cyc("R5");

        // R1: primary bits merged
        prim_lock = 8'b0101_0101; cyc("R1");
        prim_lock = 8'b1010_1010; cyc("R1");
        prim_lock = 8'h00;        cyc("R1");

        // R6: interlock window
        rd_sel = 0; wr_sel = 0;
        ilk_write = 1; wr_en = 1; wr_data = 16'h003F; cyc("R6");
        ilk_write = 0; wr_data = 16'h0000; cyc("R6");
        wr_en = 0; cyc("R6");
        op_done = 1; wr_en = 1; wr_data = 16'h0001; cyc("R6");
        op_done = 0; wr_data = 16'h0002; cyc("R6");
        idle(); cyc("R6");
        ilk_write = 1; op_done = 1; cyc("R6");
        idle(); wr_en = 1; wr_data = 16'h0000; cyc("R6");
        idle(); op_done = 1; cyc("R6");
        idle(); cyc("R6");

        // R7: suspended high-voltage operation
        hv_suspended = 1; wr_en = 1; wr_data = 16'h0015; cyc("R7");
        idle(); cyc("R7");
        hv_suspended = 0; cyc("R7");

        // R10: reads alone change nothing
        for (int k = 0; k < 6; k++) begin
            rd_sel = k[0]; cyc("R10");
        end

        // R5: mask changed outside reset has no effect
        sect_present = 8'hFF; wr_en = 1; wr_sel = 1; wr_data = 16'h0000; cyc("R5");
        idle(); rd_sel = 1; cyc("R5");

        // mixed random traffic
        for (int n = 0; n < 2000; n++) begin
            rst          = ($urandom % 60) == 0;
            cfg_word     = 18'($urandom);
            sect_present = 8'($urandom);
            sec_enable   = ($urandom % 5) != 0;
            hv_suspended = ($urandom % 6) == 0;
            ilk_write    = ($urandom % 12) == 0;
            op_done      = ($urandom % 6) == 0;
            wr_en        = ($urandom % 2) == 0;
            wr_sel       = 1'($urandom);
            wr_data      = 16'($urandom);
            rd_sel       = 1'($urandom);
            prim_lock    = 8'($urandom);
            cyc("R9");
        end
        finish_run();
    end
endmodule